// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading two page-table entries from memory, one after the other. A requester presents a virtual address and an access kind (read or write). The walker takes the base of the current first-level table from the `root_ptr` input at the moment it accepts the request. It then reads the first-level entry and checks it. If that entry is usable, it reads the second-level entry from the table that the first entry names and checks that one too. It answers with a single response: either a physical address, or one of three fault codes.

Each entry is a 32-bit word. Bit 0 says whether the page exists. Bit 1 says whether it is resident in primary memory. Bit 2 grants read access and bit 3 grants write access. Bits 11:4 are reserved. Bits 31:12 hold a page number: a physical page number when the page is resident, or a disk page number when it is not. The virtual address splits into a first-level index in bits 31:22, a second-level index in bits 21:12 and a byte offset in bits 11:0. Pages are 4 KB and entries are 4 bytes.

The memory side is a word-read port that carries one read at a time. A one-cycle strobe issues the read, and memory answers after any latency with a one-cycle data-valid pulse. The walker accepts a new request only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1 and both `mem_rd_valid` and `rsp_valid` are 0. A request driven during reset starts no read.
- R2: In the cycle after a request is accepted, `mem_rd_valid` pulses with `mem_rd_addr` = `root_ptr` (as sampled at acceptance) + 4 × vaddr[31:22].
- R3: When the first-level entry has bit 0 = 1 and bit 1 = 1, a second read is issued in the cycle after its data arrives. Its address is entry[31:12] shifted left by 12, plus 4 × vaddr[21:12].
- R4: On success, `rsp_valid` pulses in the cycle after the second-level data arrives. The outputs are `rsp_fault` = 0, `rsp_level` = 1 and `rsp_paddr` = {entry[31:12], vaddr[11:0]}. Reserved bits 11:4 have no effect.
- R5: An entry with bit 0 = 0 at either level ends the walk with `rsp_fault` = 1. `rsp_level` is 0 for the first level and 1 for the second, `rsp_paddr` = 0, and no further read is issued.
- R6: An entry with bit 0 = 1 and bit 1 = 0 ends the walk with `rsp_fault` = 2, `rsp_dpn` = entry[31:12] and the level reported as in R5. In every other response `rsp_dpn` is 0.
- R7: For a resident second-level entry, a write request with bit 3 clear, or a read request with bit 2 clear, gives `rsp_fault` = 3 and `rsp_paddr` = 0. The permission bits of the first-level entry are ignored.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after the `rsp_valid` pulse. `rsp_valid` lasts exactly one cycle. A `req_valid` held or changed while busy is not accepted.
- R9: Changes to `root_ptr`, `req_vaddr` or `req_write` after acceptance do not affect the walk in progress.
- R10: Each read strobe lasts one cycle. No new read is issued until the previous one's data has arrived, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_ptr | input | 32 | Byte address of the current first-level table, sampled on acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; a request is accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_valid | output | 1 | One-cycle read strobe toward memory |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_done | input | 1 | One-cycle pulse: read data is valid |
| mem_rd_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address on success, else 0 |
| rsp_fault | output | 2 | 0 none, 1 page absent, 2 page on disk, 3 access denied |
| rsp_level | output | 1 | Level of the last entry examined: 0 first, 1 second |
| rsp_dpn | output | 20 | Disk page number when `rsp_fault` is 2, else 0 |

## Verification
The assertions assume that memory raises `mem_rd_done` only while a read is outstanding, at least one cycle after the strobe and once per strobe. They also assume that `root_ptr` names a word-aligned table. The bench memory model arms itself only on an observed strobe and answers after a programmed latency of one to five cycles. It is given only aligned roots. Meanwhile the requester side deliberately keeps `req_valid` high and scrambles the address, access kind and root through the whole walk, to probe acceptance and sampling.

// File: rtl/pgw_pkg.sv
// Package: shared types for the two-level page table walker.
// Holds the walk state encoding, the response fault codes and the
// bit positions of the flag field in a page-table entry.
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_WT2  = 3'd4,
        ST_RSP  = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_ON_DISK = 2'd2,
        FLT_PROT    = 2'd3
    } fault_t;

    localparam int PTE_EXISTS_BIT   = 0;
    localparam int PTE_RESIDENT_BIT = 1;
    localparam int PTE_READ_BIT     = 2;
    localparam int PTE_WRITE_BIT    = 3;

endpackage

// File: rtl/pgw_addr_gen.sv
// Module: pgw_addr_gen
// Forms the byte address of the entry to fetch at the current level.
// Assumes entries are four bytes and that ADDR_W = 2*IDX_W + OFF_W.
// Purely combinational.
module pgw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    localparam int PN_W  = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [PN_W-1:0]   tbl_pn,
    input  logic              second,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int L2_LSB = OFF_W;
    localparam int L1_LSB = OFF_W + IDX_W;
    localparam int PAD_W  = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  idx1, idx2;
    logic [ADDR_W-1:0] base2;

    // Split the virtual address and build the second-level table base.
    always_comb begin
        idx1  = vaddr[L1_LSB +: IDX_W];
        idx2  = vaddr[L2_LSB +: IDX_W];
        base2 = {tbl_pn, {OFF_W{1'b0}}};
    end

    // Select base and scaled index for the active level.
    always_comb begin
        if (second)
            entry_addr = base2 + {{PAD_W{1'b0}}, idx2, 2'b00};
        else
            entry_addr = root + {{PAD_W{1'b0}}, idx1, 2'b00};
    end
endmodule

// File: rtl/pgw_pte_check.sv
// Module: pgw_pte_check
// Classifies a fetched entry: absent, held on disk, access denied or usable.
// Permission bits are examined only for the final (leaf) level.
// Purely combinational; the caller decides when the data is valid.
module pgw_pte_check #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    localparam int PN_W  = ADDR_W - OFF_W
) (
    input  logic [3:0]      flags,
    input  logic [PN_W-1:0] pte_pn,
    input  logic            leaf,
    input  logic            is_write,
    output pgw_pkg::fault_t fault,
    output logic [PN_W-1:0] pn
);
    import pgw_pkg::*;

    logic perm_ok;

    // Pick the permission bit that matches the access kind.
    always_comb perm_ok = is_write ? flags[PTE_WRITE_BIT] : flags[PTE_READ_BIT];

    // Priority: existence, then residency, then permission.
    always_comb begin
        pn = pte_pn;
        if (!flags[PTE_EXISTS_BIT])
            fault = FLT_ABSENT;
        else if (!flags[PTE_RESIDENT_BIT])
            fault = FLT_ON_DISK;
        else if (leaf && !perm_ok)
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/pgw_walk_ctrl.sv
// Module: pgw_walk_ctrl
// Sequences the walk: accept, read first level, wait, read second level,
// wait, respond. Holds the captured request and the response registers.
// Assumes memory raises rd_done only while a read is outstanding.
module pgw_walk_ctrl #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    localparam int PN_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] root_ptr,
    input  logic              rd_done,
    input  pgw_pkg::fault_t   chk_fault,
    input  logic [PN_W-1:0]   chk_pn,
    output logic [ADDR_W-1:0] vaddr_q,
    output logic [ADDR_W-1:0] root_q,
    output logic              write_q,
    output logic [PN_W-1:0]   tbl_pn_q,
    output logic              level_q,
    output logic              req_ready,
    output logic              rd_valid,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic [PN_W-1:0]   rsp_dpn
);
    import pgw_pkg::*;

    walk_state_t       state;
    fault_t            fault_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [PN_W-1:0]   dpn_q;

    // Walk state machine and request/response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            vaddr_q  <= '0;
            root_q   <= '0;
            write_q  <= 1'b0;
            tbl_pn_q <= '0;
            level_q  <= 1'b0;
            fault_q  <= FLT_NONE;
            paddr_q  <= '0;
            dpn_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    root_q  <= root_ptr;
                    write_q <= req_write;
                    level_q <= 1'b0;
                    state   <= ST_RD1;
                end
                ST_RD1: state <= ST_WT1;
                ST_WT1: if (rd_done) begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        dpn_q   <= (chk_fault == FLT_ON_DISK) ? chk_pn : '0;
                        paddr_q <= '0;
                        state   <= ST_RSP;
                    end else begin
                        tbl_pn_q <= chk_pn;
                        level_q  <= 1'b1;
                        state    <= ST_RD2;
                    end
                end
                ST_RD2: state <= ST_WT2;
                ST_WT2: if (rd_done) begin
                    fault_q <= chk_fault;
                    dpn_q   <= (chk_fault == FLT_ON_DISK) ? chk_pn : '0;
                    paddr_q <= (chk_fault == FLT_NONE) ? {chk_pn, vaddr_q[OFF_W-1:0]} : '0;
                    state   <= ST_RSP;
                end
                ST_RSP:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode handshake outputs from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rd_valid  = (state == ST_RD1) || (state == ST_RD2);
        rsp_valid = (state == ST_RSP);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
        rsp_dpn   = dpn_q;
    end

    // R10: a read strobe never lasts two cycles.
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8: acceptance drops ready and issues the first read next cycle.
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && rd_valid);
    // R8: the response is a single cycle followed by idle.
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready && !rsp_valid);
    // R5: a faulting response carries no physical address.
    p_fault_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0);
    // R6: the disk page number appears only with the on-disk fault.
    p_dpn_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd2) |-> rsp_dpn == '0);
endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Two-level page table walker: one request at a time, one memory read
// outstanding at a time, one response per request.
// Assumes root_ptr is word-aligned and memory answers once per strobe.
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    localparam int PN_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_ptr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_done,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              rsp_level,
    output logic [PN_W-1:0]   rsp_dpn
);
    import pgw_pkg::*;

    logic [ADDR_W-1:0] vaddr_q, root_q;
    logic              write_q, level_q;
    logic [PN_W-1:0]   tbl_pn_q, chk_pn;
    fault_t            chk_fault;

    pgw_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_write (req_write),
        .root_ptr  (root_ptr),
        .rd_done   (mem_rd_done),
        .chk_fault (chk_fault),
        .chk_pn    (chk_pn),
        .vaddr_q   (vaddr_q),
        .root_q    (root_q),
        .write_q   (write_q),
        .tbl_pn_q  (tbl_pn_q),
        .level_q   (level_q),
        .req_ready (req_ready),
        .rd_valid  (mem_rd_valid),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault),
        .rsp_dpn   (rsp_dpn)
    );

    pgw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .root       (root_q),
        .vaddr      (vaddr_q),
        .tbl_pn     (tbl_pn_q),
        .second     (level_q),
        .entry_addr (mem_rd_addr)
    );

    pgw_pte_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
        .flags    (mem_rd_data[3:0]),
        .pte_pn   (mem_rd_data[ADDR_W-1:OFF_W]),
        .leaf     (level_q),
        .is_write (write_q),
        .fault    (chk_fault),
        .pn       (chk_pn)
    );

    // Report the level of the last entry examined.
    always_comb rsp_level = level_q;

    // R2: the first read targets the sampled root plus the scaled first index.
    p_l1_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_rd_addr ==
            ($past(root_ptr) + ADDR_W'({$past(req_vaddr[ADDR_W-1 -: IDX_W]), 2'b00})));
    // R4: a success is only ever reported for a second-level entry.
    p_ok_is_leaf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == 2'd0) |-> rsp_level);
endmodule

// File: tb/sim_pt_walker.sv
// Bench for pt_walker: a behavioural reference model runs alongside the
// design and is compared on every cycle; directed transactions add
// named end-to-end checks.
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_ptr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_done = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_level;
    logic [19:0] rsp_dpn;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_level(rsp_level), .rsp_dpn(rsp_dpn)
    );

    int errs = 0;
    int checks = 0;
    bit cmp_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Sparse memory image and its responder.
    logic [31:0] memv [logic [31:0]];
    int lat = 1;
    int cnt = 0;
    bit pend = 1'b0;
    logic [31:0] pend_addr;

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return memv.exists(a) ? memv[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rd_done = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mem_rd_done = 1'b1;
                mem_rd_data = rdmem(pend_addr);
                pend = 1'b0;
            end else cnt--;
        end
        if (rst_n && mem_rd_valid) begin
            pend = 1'b1;
            cnt = lat;
            pend_addr = mem_rd_addr;
        end
    end

    // Reference model: phase 0 idle, 1 read1, 2 wait1, 3 read2, 4 wait2, 5 respond.
    int m_ph = 0;
    logic [31:0] m_va, m_root, m_paddr;
    logic [19:0] m_tbl, m_dpn;
    logic        m_wr, m_lvl;
    logic [1:0]  m_code;

    function automatic logic [31:0] m_addr();
        if (m_ph == 1) return m_root + {20'h0, m_va[31:22], 2'b00};
        return {m_tbl, 12'h0} + {20'h0, m_va[21:12], 2'b00};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_ph = 0;
        else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_va = req_vaddr; m_wr = req_write; m_root = root_ptr;
                    m_lvl = 1'b0; m_ph = 1;
                end
                1: m_ph = 2;
                2: if (mem_rd_done) begin
                    m_paddr = 0; m_dpn = 0;
                    if (!mem_rd_data[0]) begin m_code = 1; m_ph = 5; end
                    else if (!mem_rd_data[1]) begin
                        m_code = 2; m_dpn = mem_rd_data[31:12]; m_ph = 5;
                    end else begin
                        m_tbl = mem_rd_data[31:12]; m_lvl = 1'b1; m_ph = 3;
                    end
                end
                3: m_ph = 4;
                4: if (mem_rd_done) begin
                    m_paddr = 0; m_dpn = 0;
                    if (!mem_rd_data[0]) m_code = 1;
                    else if (!mem_rd_data[1]) begin m_code = 2; m_dpn = mem_rd_data[31:12]; end
                    else if (m_wr ? !mem_rd_data[3] : !mem_rd_data[2]) m_code = 3;
                    else begin m_code = 0; m_paddr = {mem_rd_data[31:12], m_va[11:0]}; end
                    m_ph = 5;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(req_ready == (m_ph == 0), "R8", "req_ready", 32'(req_ready), 32'(m_ph == 0));
            chk(mem_rd_valid == (m_ph == 1 || m_ph == 3), "R10", "mem_rd_valid",
                32'(mem_rd_valid), 32'(m_ph == 1 || m_ph == 3));
            if (m_ph == 1) chk(mem_rd_addr == m_addr(), "R2", "level-1 addr", mem_rd_addr, m_addr());
            if (m_ph == 3) chk(mem_rd_addr == m_addr(), "R3", "level-2 addr", mem_rd_addr, m_addr());
            chk(rsp_valid == (m_ph == 5), "R8", "rsp_valid", 32'(rsp_valid), 32'(m_ph == 5));
            if (m_ph == 5) begin
                chk(rsp_fault == m_code, "R5", "fault code", 32'(rsp_fault), 32'(m_code));
                chk(rsp_paddr == m_paddr, "R4", "paddr", rsp_paddr, m_paddr);
                chk(rsp_dpn == m_dpn, "R6", "dpn", 32'(rsp_dpn), 32'(m_dpn));
                chk(rsp_level == m_lvl, "R5", "level", 32'(rsp_level), 32'(m_lvl));
            end
        end
    end

    // One directed transaction; inputs are scrambled after acceptance (R9).
    task automatic run(input logic [31:0] va, input bit wr, input logic [31:0] root,
                       input int l, input logic [1:0] ecode, input logic [31:0] epa,
                       input logic [19:0] edpn, input bit elvl, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        lat = l; root_ptr = root; req_vaddr = va; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R8", "busy after accept", 32'(req_ready), 32'h0);
        req_vaddr = ~va; req_write = ~wr; root_ptr = 32'h000D_0000;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_fault == ecode, tag, "fault", 32'(rsp_fault), 32'(ecode));
        chk(rsp_paddr == epa, tag, "paddr", rsp_paddr, epa);
        chk(rsp_dpn == edpn, tag, "dpn", 32'(rsp_dpn), 32'(edpn));
        chk(rsp_level == elvl, tag, "level", 32'(rsp_level), 32'(elvl));
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        memv[32'h0001_0004] = 32'h0002_0003;
        memv[32'h0002_000C] = 32'h0ABC_DFFF;
        memv[32'h0002_0010] = 32'h1234_5007;
        memv[32'h0002_0014] = 32'h1111_100B;
        memv[32'h0001_000C] = 32'h0077_7001;
        memv[32'h0002_0018] = 32'hFFFF_FFFE;
        memv[32'h0002_001C] = 32'h0ABC_D00D;
        memv[32'h0001_0010] = 32'h0003_0003;
        memv[32'h0003_0000] = 32'h0004_400F;
        memv[32'h0005_0000] = 32'h0002_0003;
        memv[32'h0001_0FFC] = 32'h0006_0003;
        memv[32'h0006_0FFC] = 32'h0FED_C007;

        // R1: reset state, with a request driven during reset.
        req_valid = 1'b1; req_vaddr = 32'h0040_3ABC; root_ptr = 32'h0001_0000;
        repeat (3) @(negedge clk);
        chk(req_ready, "R1", "ready in reset", 32'(req_ready), 32'h1);
        chk(!mem_rd_valid, "R1", "no read in reset", 32'(mem_rd_valid), 32'h0);
        chk(!rsp_valid, "R1", "no rsp in reset", 32'(rsp_valid), 32'h0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_rd_valid && !rsp_valid, "R1", "after release",
            {29'h0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);
        cmp_on = 1'b1;

        run(32'h0040_3ABC, 1'b0, 32'h0001_0000, 1, 2'd0, 32'h0ABC_DABC, 20'h0, 1'b1, "R4");
        run(32'h0040_3123, 1'b1, 32'h0001_0000, 3, 2'd0, 32'h0ABC_D123, 20'h0, 1'b1, "R4");
        run(32'h0040_4010, 1'b1, 32'h0001_0000, 2, 2'd3, 32'h0, 20'h0, 1'b1, "R7");
        run(32'h0040_4010, 1'b0, 32'h0001_0000, 1, 2'd0, 32'h1234_5010, 20'h0, 1'b1, "R7");
        run(32'h0040_5008, 1'b0, 32'h0001_0000, 4, 2'd3, 32'h0, 20'h0, 1'b1, "R7");
        run(32'h0040_5008, 1'b1, 32'h0001_0000, 1, 2'd0, 32'h1111_1008, 20'h0, 1'b1, "R7");
        run(32'h0080_0000, 1'b0, 32'h0001_0000, 2, 2'd1, 32'h0, 20'h0, 1'b0, "R5");
        run(32'h00C0_0000, 1'b0, 32'h0001_0000, 5, 2'd2, 32'h0, 20'h00777, 1'b0, "R6");
        run(32'h0040_6000, 1'b0, 32'h0001_0000, 1, 2'd1, 32'h0, 20'h0, 1'b1, "R5");
        run(32'h0040_7FFF, 1'b1, 32'h0001_0000, 3, 2'd2, 32'h0, 20'h0ABCD, 1'b1, "R6");
        run(32'h0100_0777, 1'b1, 32'h0001_0000, 2, 2'd0, 32'h0004_4777, 20'h0, 1'b1, "R7");
        run(32'h0000_3FFF, 1'b0, 32'h0005_0000, 5, 2'd0, 32'h0ABC_DFFF, 20'h0, 1'b1, "R9");
        run(32'hFFFF_F001, 1'b0, 32'h0001_0000, 1, 2'd0, 32'h0FED_C001, 20'h0, 1'b1, "R3");
        run(32'h0040_3ABC, 1'b0, 32'h0001_0000, 5, 2'd0, 32'h0ABC_DABC, 20'h0, 1'b1, "R10");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule